// File: doc/BRIEF.md
# Paged Address Window and Region Decoder

This block sits between a 16-bit CPU address bus and a memory system whose physical space is 24 bits wide. A programmable window, given by a start and an exclusive end address, moves a slice of the CPU space onto any page of the wide space. The physical address is formed from the offset into the window, a page number scaled by a programmable shift, and a programmable base. Addresses outside the window pass through zero-extended.

In parallel, the block decides which of four regions answers the CPU address. The regions are a relocatable I/O register block, a fixed EEPROM range, a relocatable internal RAM, and external RAM. A one-byte placement register sets the 4 KiB slots of the I/O block and the internal RAM. When regions overlap, a fixed priority picks the winner. External RAM is the fallback when no other region claims the address.

Configuration is loaded through a simple write port. Decoding is purely combinational from the current CPU address and the registered configuration.

Top module: `paged_map_top`

## Requirements
- R1: When wstart <= cpu_addr < wend, phys_addr = (cpu_addr - wstart) + (page << shift) + vbase.
- R2: The window start is inclusive and the window end is exclusive. An address equal to wend is not translated.
- R3: Outside the window, phys_addr equals cpu_addr zero-extended to 24 bits.
- R4: The translated sum is taken modulo 2^24. Page bits shifted above bit 23 are lost, and a base near the top of the space wraps to low addresses.
- R5: The I/O block starts at placement[3:0] << 12. It spans 64 bytes when WIDE_IO=0 and 1024 bytes when WIDE_IO=1.
- R6: The internal RAM starts at (placement & 0xF0) << 8 and spans RAM_SPAN bytes (default 256).
- R7: region_sel is one-hot, with bit0 = I/O, bit1 = EEPROM (EE_BASE 0xB000, EE_SPAN 0x800 by default), bit2 = internal RAM and bit3 = external RAM. Where regions overlap, the priority is I/O over EEPROM over internal RAM.
- R8: External RAM (bit3) is selected exactly when no other region claims the address.
- R9: A write with wr_en=1 loads the register chosen by wr_addr on the next rising edge. The codes are: 0 placement (wr_data[7:0]), 1 page (wr_data[7:0]), 2 wstart, 3 wend, 4 shift (wr_data[4:0]), 5 vbase[15:0], 6 vbase[23:16] (wr_data[7:0]). Outputs in the write cycle still reflect the old value.
- R10: A write with wr_addr=7 changes no register.
- R11: Reset clears every configuration register to zero. After reset, every address passes through unchanged, and the I/O block and internal RAM both sit at 0x0000.
- R12: A window with wstart >= wend is empty and translates no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register code |
| wr_data | input | 16 | Configuration write data |
| cpu_addr | input | 16 | CPU address to decode |
| phys_addr | output | 24 | Translated physical address |
| region_sel | output | 4 | One-hot region select |

## Verification
The bench builds two copies side by side on the same stimulus. One uses WIDE_IO=0 and the other WIDE_IO=1, both with the default EEPROM at 0xB000 and a 256-byte internal RAM. Offsets 0x40 to 0x3FF above the I/O base then decode differently in the two copies, which exposes the span boundary and the I/O-over-RAM and I/O-over-EEPROM overlaps. The default 24-bit physical width with a 5-bit shift makes it possible to shift page bits completely out and to wrap the sum past 0xFFFFFF.

// File: rtl/paged_map_pkg.sv
package paged_map_pkg;

  // configuration register codes seen on the write port
  typedef enum logic [2:0] {
    CFG_PLACE    = 3'd0,
    CFG_PAGE     = 3'd1,
    CFG_WSTART   = 3'd2,
    CFG_WEND     = 3'd3,
    CFG_SHIFT    = 3'd4,
    CFG_VBASE_LO = 3'd5,
    CFG_VBASE_HI = 3'd6,
    CFG_SPARE    = 3'd7
  } cfg_code_e;

  // region indices, highest priority first
  localparam int RGN_IO    = 0;
  localparam int RGN_EE    = 1;
  localparam int RGN_IRAM  = 2;
  localparam int RGN_EXT   = 3;
  localparam int NUM_RGN   = 4;
  localparam int NUM_CLAIM = 3;

endpackage

// File: rtl/map_cfg_regs.sv
module map_cfg_regs
  import paged_map_pkg::*;
#(
  parameter int CPU_AW  = 16,
  parameter int PHYS_AW = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 5,
  parameter int PLACE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CPU_AW-1:0]  wr_data,
  output logic [PLACE_W-1:0] place_q,
  output logic [PAGE_W-1:0]  page_q,
  output logic [CPU_AW-1:0]  wstart_q,
  output logic [CPU_AW-1:0]  wend_q,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [PHYS_AW-1:0] vbase_q
);

  localparam int VB_HI_W = PHYS_AW - CPU_AW;

  cfg_code_e          wr_code;
  logic               en_place, en_page, en_wstart, en_wend;
  logic               en_shift, en_vb_lo, en_vb_hi;
  logic [PLACE_W-1:0] place_d;
  logic [PAGE_W-1:0]  page_d;
  logic [SHIFT_W-1:0] shift_d;
  logic [PHYS_AW-1:0] vbase_d;

  // next-state: decode the code into one enable per register
  always_comb begin
    wr_code   = cfg_code_e'(wr_addr);
    en_place  = wr_en && (wr_code == CFG_PLACE);
    en_page   = wr_en && (wr_code == CFG_PAGE);
    en_wstart = wr_en && (wr_code == CFG_WSTART);
    en_wend   = wr_en && (wr_code == CFG_WEND);
    en_shift  = wr_en && (wr_code == CFG_SHIFT);
    en_vb_lo  = wr_en && (wr_code == CFG_VBASE_LO);
    en_vb_hi  = wr_en && (wr_code == CFG_VBASE_HI);
    place_d   = wr_data[PLACE_W-1:0];
    page_d    = wr_data[PAGE_W-1:0];
    shift_d   = wr_data[SHIFT_W-1:0];
    vbase_d   = vbase_q;
    if (en_vb_lo) vbase_d[CPU_AW-1:0]       = wr_data;
    if (en_vb_hi) vbase_d[PHYS_AW-1:CPU_AW] = wr_data[VB_HI_W-1:0];
  end

  // registers, each with an explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      place_q <= '0;
    end else if (en_place) begin
      place_q <= place_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (en_page) begin
      page_q <= page_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wstart_q <= '0;
    end else if (en_wstart) begin
      wstart_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wend_q <= '0;
    end else if (en_wend) begin
      wend_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (en_shift) begin
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbase_q <= '0;
    end else if (en_vb_lo || en_vb_hi) begin
      vbase_q <= vbase_d;
    end
  end

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int CPU_AW  = 16,
  parameter int PHYS_AW = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 5
) (
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [CPU_AW-1:0]  wstart,
  input  logic [CPU_AW-1:0]  wend,
  input  logic [PAGE_W-1:0]  page,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [PHYS_AW-1:0] vbase,
  output logic [PHYS_AW-1:0] phys_addr
);

  localparam int EXT_W  = PHYS_AW - CPU_AW;
  localparam int PEXT_W = PHYS_AW - PAGE_W;

  logic               in_win;
  logic [CPU_AW-1:0]  offset;
  logic [PHYS_AW-1:0] page_term;
  logic [PHYS_AW-1:0] mapped;

  always_comb begin
    in_win    = (cpu_addr >= wstart) && (cpu_addr < wend);
    offset    = cpu_addr - wstart;
    page_term = {{PEXT_W{1'b0}}, page} << shift;
    mapped    = {{EXT_W{1'b0}}, offset} + page_term + vbase;
    phys_addr = in_win ? mapped : {{EXT_W{1'b0}}, cpu_addr};
  end

endmodule

// File: rtl/region_sel_dec.sv
module region_sel_dec
  import paged_map_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int PLACE_W  = 8,
  parameter int IO_SPAN  = 64,
  parameter int EE_BASE  = 'hB000,
  parameter int EE_SPAN  = 'h800,
  parameter int RAM_SPAN = 256
) (
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [PLACE_W-1:0] place,
  output logic [NUM_RGN-1:0] region_sel
);

  localparam int NIB_W = PLACE_W / 2;
  localparam int LOW_W = CPU_AW - NIB_W;
  localparam logic [CPU_AW:0] IO_SPAN_W  = (CPU_AW+1)'(IO_SPAN);
  localparam logic [CPU_AW:0] EE_BASE_W  = (CPU_AW+1)'(EE_BASE);
  localparam logic [CPU_AW:0] EE_SPAN_W  = (CPU_AW+1)'(EE_SPAN);
  localparam logic [CPU_AW:0] RAM_SPAN_W = (CPU_AW+1)'(RAM_SPAN);

  logic [CPU_AW:0]    rgn_lo   [NUM_CLAIM];
  logic [CPU_AW:0]    rgn_span [NUM_CLAIM];
  logic [NUM_CLAIM-1:0] hit;
  logic [CPU_AW:0]    addr_x;

  always_comb begin
    addr_x             = {1'b0, cpu_addr};
    rgn_lo[RGN_IO]     = {1'b0, place[NIB_W-1:0], {LOW_W{1'b0}}};
    rgn_span[RGN_IO]   = IO_SPAN_W;
    rgn_lo[RGN_EE]     = EE_BASE_W;
    rgn_span[RGN_EE]   = EE_SPAN_W;
    rgn_lo[RGN_IRAM]   = {1'b0, place[PLACE_W-1:NIB_W], {LOW_W{1'b0}}};
    rgn_span[RGN_IRAM] = RAM_SPAN_W;
  end

  // one range comparator per claimable region
  for (genvar g = 0; g < NUM_CLAIM; g++) begin : g_cmp
    assign hit[g] = (addr_x >= rgn_lo[g]) && (addr_x < (rgn_lo[g] + rgn_span[g]));
  end

  // fixed priority: lowest index wins, external RAM takes the rest
  always_comb begin
    logic claimed;
    claimed    = 1'b0;
    region_sel = '0;
    for (int i = 0; i < NUM_CLAIM; i++) begin
      if (hit[i] && !claimed) begin
        region_sel[i] = 1'b1;
        claimed       = 1'b1;
      end
    end
    region_sel[RGN_EXT] = !claimed;
  end

endmodule

// File: rtl/paged_map_top.sv
module paged_map_top
  import paged_map_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int PHYS_AW  = 24,
  parameter int PAGE_W   = 8,
  parameter int SHIFT_W  = 5,
  parameter int PLACE_W  = 8,
  parameter bit WIDE_IO  = 1'b0,
  parameter int EE_BASE  = 'hB000,
  parameter int EE_SPAN  = 'h800,
  parameter int RAM_SPAN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CPU_AW-1:0]  wr_data,
  input  logic [CPU_AW-1:0]  cpu_addr,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic [NUM_RGN-1:0] region_sel
);

  localparam int IO_SPAN = WIDE_IO ? 1024 : 64;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [PLACE_W-1:0] place_q;
  logic [PAGE_W-1:0]  page_q;
  logic [CPU_AW-1:0]  wstart_q;
  logic [CPU_AW-1:0]  wend_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [PHYS_AW-1:0] vbase_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  map_cfg_regs #(
    .CPU_AW (CPU_AW),
    .PHYS_AW(PHYS_AW),
    .PAGE_W (PAGE_W),
    .SHIFT_W(SHIFT_W),
    .PLACE_W(PLACE_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .place_q (place_q),
    .page_q  (page_q),
    .wstart_q(wstart_q),
    .wend_q  (wend_q),
    .shift_q (shift_q),
    .vbase_q (vbase_q)
  );

  bank_xlate #(
    .CPU_AW (CPU_AW),
    .PHYS_AW(PHYS_AW),
    .PAGE_W (PAGE_W),
    .SHIFT_W(SHIFT_W)
  ) u_xlate (
    .cpu_addr (cpu_addr),
    .wstart   (wstart_q),
    .wend     (wend_q),
    .page     (page_q),
    .shift    (shift_q),
    .vbase    (vbase_q),
    .phys_addr(phys_addr)
  );

  region_sel_dec #(
    .CPU_AW  (CPU_AW),
    .PLACE_W (PLACE_W),
    .IO_SPAN (IO_SPAN),
    .EE_BASE (EE_BASE),
    .EE_SPAN (EE_SPAN),
    .RAM_SPAN(RAM_SPAN)
  ) u_dec (
    .cpu_addr  (cpu_addr),
    .place     (place_q),
    .region_sel(region_sel)
  );

endmodule

// File: rtl/paged_map_chk.sv
module paged_map_chk #(
  parameter int CPU_AW  = 16,
  parameter int PHYS_AW = 24,
  parameter int PAGE_W  = 8,
  parameter int PLACE_W = 8,
  parameter int IO_SPAN = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [2:0]         wr_addr,
  input logic [CPU_AW-1:0]  wr_data,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic [PHYS_AW-1:0] phys_addr,
  input logic [3:0]         region_sel,
  input logic [PLACE_W-1:0] place_q,
  input logic [PAGE_W-1:0]  page_q,
  input logic [CPU_AW-1:0]  wstart_q,
  input logic [CPU_AW-1:0]  wend_q
);

  localparam int NIB_W = PLACE_W / 2;
  localparam int LOW_W = CPU_AW - NIB_W;

  logic [CPU_AW:0] io_lo;
  logic            in_io;
  logic            outside;

  always_comb begin
    io_lo   = {1'b0, place_q[NIB_W-1:0], {LOW_W{1'b0}}};
    in_io   = ({1'b0, cpu_addr} >= io_lo) &&
              ({1'b0, cpu_addr} < io_lo + (CPU_AW+1)'(IO_SPAN));
    outside = (cpu_addr < wstart_q) || (cpu_addr >= wend_q);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(region_sel) == 1); // R7

  AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (phys_addr == {{(PHYS_AW-CPU_AW){1'b0}}, cpu_addr})); // R3

  AST_IO_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_io |-> (region_sel == 4'b0001)); // R5

  AST_PLACE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> (place_q == $past(wr_data[PLACE_W-1:0]))); // R9

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd1) |=> $stable(page_q)); // R10

endmodule

bind paged_map_top paged_map_chk #(
  .CPU_AW (CPU_AW),
  .PHYS_AW(PHYS_AW),
  .PAGE_W (PAGE_W),
  .PLACE_W(PLACE_W),
  .IO_SPAN(IO_SPAN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .cpu_addr  (cpu_addr),
  .phys_addr (phys_addr),
  .region_sel(region_sel),
  .place_q   (place_q),
  .page_q    (page_q),
  .wstart_q  (wstart_q),
  .wend_q    (wend_q)
);

// File: tb/paged_map_top_bench.sv
`timescale 1ns/1ps
module paged_map_top_bench;

  localparam int EE_LO  = 'hB000;
  localparam int EE_SZ  = 'h800;
  localparam int RAM_SZ = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] cpu_addr;
  logic [23:0] phys_n, phys_w;
  logic [3:0]  sel_n, sel_w;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  paged_map_top #(.WIDE_IO(1'b0), .EE_BASE(EE_LO), .EE_SPAN(EE_SZ), .RAM_SPAN(RAM_SZ)) u_paged_map_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .phys_addr(phys_n), .region_sel(sel_n));

  paged_map_top #(.WIDE_IO(1'b1), .EE_BASE(EE_LO), .EE_SPAN(EE_SZ), .RAM_SPAN(RAM_SZ)) u_paged_map_top_wide (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_addr(cpu_addr), .phys_addr(phys_w), .region_sel(sel_w));

  // behavioural reference state
  int m_place, m_page, m_ws, m_we, m_sh, m_vb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_place <= 0; m_page <= 0; m_ws <= 0; m_we <= 0; m_sh <= 0; m_vb <= 0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: m_place <= int'(wr_data) % 256;
        3'd1: m_page  <= int'(wr_data) % 256;
        3'd2: m_ws    <= int'(wr_data);
        3'd3: m_we    <= int'(wr_data);
        3'd4: m_sh    <= int'(wr_data) % 32;
        3'd5: m_vb    <= (m_vb / 65536) * 65536 + int'(wr_data);
        3'd6: m_vb    <= (int'(wr_data) % 256) * 65536 + (m_vb % 65536);
        default: ;
      endcase
    end
  end

  function automatic longint exp_phys(int a);
    longint t;
    if (a >= m_ws && a < m_we)
      t = longint'(a - m_ws) + (longint'(m_page) << m_sh) + longint'(m_vb);
    else
      t = a;
    return t % (64'd1 << 24);
  endfunction

  function automatic int exp_sel(int a, int io_span);
    int iob = (m_place % 16) * 4096;
    int rb  = (m_place / 16) * 4096;
    if (a >= iob && a < iob + io_span) return 1;
    if (a >= EE_LO && a < EE_LO + EE_SZ) return 2;
    if (a >= rb && a < rb + RAM_SZ) return 4;
    return 8;
  endfunction

  task automatic check(string tag);
    int     a  = int'(cpu_addr);
    longint ep = exp_phys(a);
    int     en = exp_sel(a, 64);
    int     ew = exp_sel(a, 1024);
    checks++;
    if (longint'(phys_n) != ep || int'(sel_n) != en) begin
      errors++;
      $display("FAIL %s narrow addr=%h actual phys=%h sel=%b expected phys=%h sel=%b",
               tag, cpu_addr, phys_n, sel_n, ep[23:0], en[3:0]);
    end
    checks++;
    if (longint'(phys_w) != ep || int'(sel_w) != ew) begin
      errors++;
      $display("FAIL %s wide addr=%h actual phys=%h sel=%b expected phys=%h sel=%b",
               tag, cpu_addr, phys_w, sel_w, ep[23:0], ew[3:0]);
    end
  endtask

  task automatic cyc(logic [15:0] a, logic we, logic [2:0] code, logic [15:0] d, string tag);
    @(negedge clk);
    cpu_addr = a; wr_en = we; wr_addr = code; wr_data = d;
    #1;
    check(tag);
  endtask

  task automatic rd(logic [15:0] a, string tag);
    cyc(a, 1'b0, 3'd0, 16'h0000, tag);
  endtask

  task automatic wr(logic [2:0] code, logic [15:0] d, logic [15:0] a, string tag);
    cyc(a, 1'b1, code, d, tag);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 3'd0; wr_data = 16'h0; cpu_addr = 16'h0;
    // R11: reset state, pass-through, I/O and RAM at 0
    rd(16'h0010, "R11");
    rd(16'h0080, "R11");
    rd(16'h1234, "R11");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) rd(16'h4321, "R11");
    // R5 span boundaries and R7 overlap with internal RAM
    rd(16'h003F, "R7");
    rd(16'h0040, "R5");
    rd(16'h03FF, "R5");
    rd(16'h0400, "R8");
    rd(16'h00FF, "R6");
    rd(16'h0100, "R8");
    // R9: placement write, old value visible during the write cycle
    wr(3'd0, 16'h00B1, 16'h1000, "R9");
    rd(16'h1000, "R5");
    rd(16'hB000, "R7");
    rd(16'hB0FF, "R7");
    wr(3'd0, 16'h00BB, 16'hB000, "R9");
    rd(16'hB000, "R7");
    rd(16'hB040, "R7");
    rd(16'hB7FF, "R7");
    rd(16'hB800, "R8");
    wr(3'd0, 16'h002B, 16'h2000, "R9");
    rd(16'h2000, "R6");
    rd(16'h20FF, "R6");
    rd(16'h2100, "R8");
    // R1/R2/R3: window translation
    wr(3'd2, 16'h8000, 16'h8000, "R9");
    wr(3'd3, 16'hC000, 16'h8000, "R9");
    wr(3'd1, 16'h0003, 16'h8000, "R9");
    wr(3'd4, 16'h000E, 16'h8000, "R9");
    wr(3'd5, 16'h0000, 16'h8000, "R9");
    wr(3'd6, 16'h0010, 16'h8000, "R9");
    rd(16'h8000, "R2");
    rd(16'h9ABC, "R1");
    rd(16'hBFFF, "R1");
    rd(16'hC000, "R2");
    rd(16'h7FFF, "R3");
    wr(3'd1, 16'h00FF, 16'h8004, "R9");
    rd(16'h8004, "R9");
    // R4: modulo 2^24
    wr(3'd6, 16'h00FF, 16'h8000, "R4");
    wr(3'd5, 16'hFFF0, 16'h8000, "R4");
    wr(3'd1, 16'h0020, 16'h8000, "R4");
    wr(3'd4, 16'h0000, 16'h8000, "R4");
    rd(16'h8000, "R4");
    wr(3'd4, 16'h001F, 16'h8001, "R4");
    rd(16'h8001, "R4");
    wr(3'd4, 16'h0011, 16'h8002, "R4");
    rd(16'h8002, "R4");
    // R10: spare code writes nothing
    wr(3'd7, 16'hFFFF, 16'h8003, "R10");
    rd(16'h8003, "R10");
    rd(16'h2000, "R10");
    // R12: empty windows
    wr(3'd2, 16'h9000, 16'h9000, "R12");
    wr(3'd3, 16'h9000, 16'h9000, "R12");
    rd(16'h9000, "R12");
    wr(3'd3, 16'h8000, 16'h8800, "R12");
    rd(16'h8800, "R12");
    // R11: reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    rd(16'h0020, "R11");
    rd(16'h9000, "R11");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) rd(16'h00C0, "R11");
    done = 1;
    summary();
    $finish;
  end

endmodule